// File: doc/BRIEF.md
# Branch next-address and condition unit

This unit works out where a 20-bit-address microcontroller core goes after a jump or branch. Each cycle the core may present one request: the address of the branch instruction, a kind code, an operand field, a 4-bit code-segment value, the 16-bit AX register, the zero and carry flags, and one already-fetched test bit. The unit decides whether control transfers, forms the next address, and reports how many execution clocks the instruction costs.

Supported kinds are short and long PC-relative jumps, 16-bit and 20-bit absolute jumps, and a jump through AX with the segment value on top. There are six flag-conditional branches, including two that test the OR of zero and carry, and bit-test branches of two lengths.

The operand field is 20 bits wide. Relative forms read bits [7:0] or [15:0] as signed displacements. Absolute forms read bits [15:0] or [19:0]. All results are registered and appear one cycle after the request strobe.

Top module: `brnext_unit`

## Requirements
- R1: While reset is asserted, and until it has been released through the two-stage synchronizer, out_valid, taken, next_pc and cycles are all 0.
- R2: A request with in_valid=1 produces out_valid=1 on the following cycle only. With in_valid=0, out_valid is 0 on the next cycle and next_pc, taken and cycles keep their values.
- R3: Kind 0 (short relative) gives next_pc = pc + 2 + sign-extended operand[7:0].
- R4: Kind 1 (long relative) gives next_pc = pc + 3 + sign-extended operand[15:0].
- R5: Kind 2 (16-bit absolute) gives next_pc = {4'h0, operand[15:0]}, ignoring operand[19:16]. Kind 3 (20-bit absolute) gives next_pc = operand[19:0].
- R6: Kind 4 (register-indirect) gives next_pc = {seg, ax}.
- R7: The 2-byte flag branches are taken on these conditions: kind 5 when cy=1, kind 6 when cy=0, kind 7 when z=1, and kind 8 when z=0. When taken, the target is pc + 2 + sign-extended operand[7:0].
- R8: Kind 9 is taken when (z|cy)=0 and kind 10 when (z|cy)=1. Both are 3 bytes long, so the taken target is pc + 3 + sign-extended operand[7:0].
- R9: Bit-test branches are taken when test_bit=1. Kind 11 is 3 bytes long and kind 12 is 4 bytes long. The taken target is pc + length + sign-extended operand[7:0].
- R10: A conditional branch that is not taken gives next_pc = pc + its length and taken=0.
- R11: cycles is 3 for kinds 0 to 4, which always report taken=1. For flag branches (kinds 5 to 10) it is 2 when not taken and 4 when taken. For bit-test branches it is 3 when not taken and 5 when taken.
- R12: Kind codes 13 to 15 are reserved and give next_pc = pc, taken=0 and cycles=0.
- R13: All next_pc arithmetic wraps modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| cur_pc | input | 20 | Address of the branch instruction |
| kind | input | 4 | Branch kind code (0 to 12, 13 to 15 reserved) |
| operand | input | 20 | Displacement or absolute address field |
| seg | input | 4 | Code-segment value for the register-indirect jump |
| ax | input | 16 | AX register value |
| flag_z | input | 1 | Zero flag |
| flag_cy | input | 1 | Carry flag |
| test_bit | input | 1 | Bit value for bit-test branches |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| next_pc | output | 20 | Next program address |
| taken | output | 1 | Control transfer happened |
| cycles | output | 3 | Execution clock count |

## Verification
The bench targets several cases where a plausible mistake gives a wrong address. A negative short displacement from address 0 shows a missing sign extension or a failure to wrap below zero. A long jump from near the top of memory shows a failure to wrap past 2^20. A 16-bit absolute operand with its upper nibble set shows whether that nibble leaks into the PC.

The compound conditions are run over all four combinations of z and cy, which exposes an AND written in place of an OR or a swapped polarity. Fall-through addresses are checked for the 2-, 3- and 4-byte forms to catch a length taken from the wrong class. Idle cycles with changed inputs expose a missing clock enable. Reserved codes confirm that no stray transfer occurs.

// File: rtl/brnext_pkg.sv
package brnext_pkg;

  typedef enum logic [3:0] {
    BK_REL8   = 4'd0,
    BK_REL16  = 4'd1,
    BK_ABS16  = 4'd2,
    BK_ABS20  = 4'd3,
    BK_REGIND = 4'd4,
    BK_IF_CY  = 4'd5,
    BK_IF_NCY = 4'd6,
    BK_IF_Z   = 4'd7,
    BK_IF_NZ  = 4'd8,
    BK_IF_HI  = 4'd9,
    BK_IF_NHI = 4'd10,
    BK_BIT_L3 = 4'd11,
    BK_BIT_L4 = 4'd12
  } br_kind_e;

  localparam int unsigned LEN_W = 3;

endpackage

// File: rtl/brnext_rstsync.sv
module brnext_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign chain_d[s] = 1'b1;
      end else begin : g_rest
        assign chain_d[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/brnext_cond.sv
module brnext_cond
  import brnext_pkg::*;
#(
  parameter int unsigned CYC_W       = 3,
  parameter int unsigned CYC_JUMP    = 3,
  parameter int unsigned CYC_FLAG_NT = 2,
  parameter int unsigned CYC_FLAG_T  = 4,
  parameter int unsigned CYC_BIT_NT  = 3,
  parameter int unsigned CYC_BIT_T   = 5
) (
  input  logic [3:0]       kind,
  input  logic             flag_z,
  input  logic             flag_cy,
  input  logic             test_bit,
  output logic             take,
  output logic [LEN_W-1:0] ilen,
  output logic [CYC_W-1:0] cyc
);
  logic hi_cond;
  logic flag_class;
  logic bit_class;

  assign hi_cond = ~(flag_z | flag_cy);

  always_comb begin
    take       = 1'b0;
    ilen       = '0;
    flag_class = 1'b0;
    bit_class  = 1'b0;
    unique case (br_kind_e'(kind))
      BK_REL8:   begin take = 1'b1; ilen = LEN_W'(2); end
      BK_REL16:  begin take = 1'b1; ilen = LEN_W'(3); end
      BK_ABS16:  begin take = 1'b1; ilen = LEN_W'(3); end
      BK_ABS20:  begin take = 1'b1; ilen = LEN_W'(4); end
      BK_REGIND: begin take = 1'b1; ilen = LEN_W'(2); end
      BK_IF_CY:  begin take = flag_cy;   ilen = LEN_W'(2); flag_class = 1'b1; end
      BK_IF_NCY: begin take = ~flag_cy;  ilen = LEN_W'(2); flag_class = 1'b1; end
      BK_IF_Z:   begin take = flag_z;    ilen = LEN_W'(2); flag_class = 1'b1; end
      BK_IF_NZ:  begin take = ~flag_z;   ilen = LEN_W'(2); flag_class = 1'b1; end
      BK_IF_HI:  begin take = hi_cond;   ilen = LEN_W'(3); flag_class = 1'b1; end
      BK_IF_NHI: begin take = ~hi_cond;  ilen = LEN_W'(3); flag_class = 1'b1; end
      BK_BIT_L3: begin take = test_bit;  ilen = LEN_W'(3); bit_class = 1'b1; end
      BK_BIT_L4: begin take = test_bit;  ilen = LEN_W'(4); bit_class = 1'b1; end
      default:   begin take = 1'b0;      ilen = '0; end
    endcase
  end

  always_comb begin
    if (flag_class)     cyc = take ? CYC_W'(CYC_FLAG_T) : CYC_W'(CYC_FLAG_NT);
    else if (bit_class) cyc = take ? CYC_W'(CYC_BIT_T)  : CYC_W'(CYC_BIT_NT);
    else if (take)      cyc = CYC_W'(CYC_JUMP);
    else                cyc = '0;
  end
endmodule

// File: rtl/brnext_target.sv
module brnext_target
  import brnext_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SEG_W  = 4,
  localparam int unsigned AX_W  = ADDR_W - SEG_W
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [3:0]        kind,
  input  logic [ADDR_W-1:0] operand,
  input  logic [SEG_W-1:0]  seg,
  input  logic [AX_W-1:0]   ax,
  input  logic              take,
  input  logic [LEN_W-1:0]  ilen,
  output logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] fall_thru;
  logic [ADDR_W-1:0] disp8_x;
  logic [ADDR_W-1:0] disp16_x;
  logic [ADDR_W-1:0] rel_disp;
  logic [ADDR_W-1:0] rel_sum;

  assign fall_thru = cur_pc + ADDR_W'(ilen);
  assign disp8_x   = {{(ADDR_W-8){operand[7]}}, operand[7:0]};
  assign disp16_x  = {{(ADDR_W-16){operand[15]}}, operand[15:0]};
  assign rel_disp  = (br_kind_e'(kind) == BK_REL16) ? disp16_x : disp8_x;
  assign rel_sum   = fall_thru + rel_disp;

  always_comb begin
    unique case (br_kind_e'(kind))
      BK_REL8, BK_REL16: target = rel_sum;
      BK_ABS16:          target = {{(ADDR_W-16){1'b0}}, operand[15:0]};
      BK_ABS20:          target = operand;
      BK_REGIND:         target = {seg, ax};
      BK_IF_CY, BK_IF_NCY, BK_IF_Z, BK_IF_NZ,
      BK_IF_HI, BK_IF_NHI, BK_BIT_L3, BK_BIT_L4:
                         target = take ? rel_sum : fall_thru;
      default:           target = cur_pc;
    endcase
  end
endmodule

// File: rtl/brnext_unit.sv
module brnext_unit
  import brnext_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned SEG_W       = 4,
  parameter int unsigned CYC_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AX_W       = ADDR_W - SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [3:0]        kind,
  input  logic [ADDR_W-1:0] operand,
  input  logic [SEG_W-1:0]  seg,
  input  logic [AX_W-1:0]   ax,
  input  logic              flag_z,
  input  logic              flag_cy,
  input  logic              test_bit,
  output logic              out_valid,
  output logic [ADDR_W-1:0] next_pc,
  output logic              taken,
  output logic [CYC_W-1:0]  cycles
);
  logic              rst_q_n;
  logic              take_c;
  logic [LEN_W-1:0]  ilen_c;
  logic [CYC_W-1:0]  cyc_c;
  logic [ADDR_W-1:0] target_c;

  logic              vld_d, tkn_d;
  logic [ADDR_W-1:0] pc_d;
  logic [CYC_W-1:0]  cyc_d;

  brnext_rstsync #(.STAGES(SYNC_STAGES)) rsync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  brnext_cond #(.CYC_W(CYC_W)) cond_i (
    .kind     (kind),
    .flag_z   (flag_z),
    .flag_cy  (flag_cy),
    .test_bit (test_bit),
    .take     (take_c),
    .ilen     (ilen_c),
    .cyc      (cyc_c)
  );

  brnext_target #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) tgt_i (
    .cur_pc  (cur_pc),
    .kind    (kind),
    .operand (operand),
    .seg     (seg),
    .ax      (ax),
    .take    (take_c),
    .ilen    (ilen_c),
    .target  (target_c)
  );

  always_comb begin
    vld_d = in_valid;
    tkn_d = taken;
    pc_d  = next_pc;
    cyc_d = cycles;
    if (in_valid) begin
      tkn_d = take_c;
      pc_d  = target_c;
      cyc_d = cyc_c;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      cycles    <= '0;
    end else begin
      out_valid <= vld_d;
      taken     <= tkn_d;
      next_pc   <= pc_d;
      cycles    <= cyc_d;
    end
  end
endmodule

// File: rtl/brnext_unit_chk.sv
module brnext_unit_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned CYC_W  = 3
) (
  input logic                     clk,
  input logic                     rst_ok,
  input logic                     in_valid,
  input logic [3:0]               kind,
  input logic [ADDR_W-1:0]        cur_pc,
  input logic [SEG_W-1:0]         seg,
  input logic [ADDR_W-SEG_W-1:0]  ax,
  input logic                     out_valid,
  input logic [ADDR_W-1:0]        next_pc,
  input logic                     taken,
  input logic [CYC_W-1:0]         cycles
);
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);  // R2
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> ($stable(next_pc) && $stable(taken) && $stable(cycles)));  // R2
  AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && kind <= 4'd4) |=> (taken && cycles == CYC_W'(3)));  // R11
  AST_ABS16_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && kind == 4'd2) |=> (next_pc[ADDR_W-1:16] == '0));  // R5
  AST_REGIND_JOIN: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && kind == 4'd4) |=> (next_pc == {$past(seg), $past(ax)}));  // R6
  AST_FLAG_CYCLES: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && kind >= 4'd5 && kind <= 4'd10) |=>
      (cycles == (taken ? CYC_W'(4) : CYC_W'(2))));  // R11
  AST_BIT_CYCLES: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && (kind == 4'd11 || kind == 4'd12)) |=>
      (cycles == (taken ? CYC_W'(5) : CYC_W'(3))));  // R11
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && kind >= 4'd13) |=>
      (!taken && cycles == '0 && next_pc == $past(cur_pc)));  // R12
endmodule

bind brnext_unit brnext_unit_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .CYC_W(CYC_W)) chk_i (
  .clk       (clk),
  .rst_ok    (rst_q_n),
  .in_valid  (in_valid),
  .kind      (kind),
  .cur_pc    (cur_pc),
  .seg       (seg),
  .ax        (ax),
  .out_valid (out_valid),
  .next_pc   (next_pc),
  .taken     (taken),
  .cycles    (cycles)
);

// File: tb/brnext_unit_tb.sv
module brnext_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [19:0] cur_pc;
  logic [3:0]  kind;
  logic [19:0] operand;
  logic [3:0]  seg;
  logic [15:0] ax;
  logic        flag_z, flag_cy, test_bit;
  logic        out_valid;
  logic [19:0] next_pc;
  logic        taken;
  logic [2:0]  cycles;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [19:0] last_pc;
  logic        last_tk;
  logic [2:0]  last_cc;

  always #4 clk = ~clk;

  brnext_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc), .kind(kind),
    .operand(operand), .seg(seg), .ax(ax), .flag_z(flag_z), .flag_cy(flag_cy),
    .test_bit(test_bit), .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
    .cycles(cycles)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [19:0] pc, input logic [3:0] k,
                                input logic [19:0] op, input logic [3:0] sg,
                                input logic [15:0] a, input logic z, input logic cy,
                                input logic tb, output logic [19:0] npc,
                                output logic tk, output logic [2:0] cc);
    logic [19:0] d8, d16;
    int len;
    d8  = {{12{op[7]}}, op[7:0]};
    d16 = {{4{op[15]}}, op[15:0]};
    tk = 1'b0; cc = 3'd0; npc = pc; len = 0;
    case (k)
      4'd0: begin tk = 1; cc = 3; npc = pc + 20'd2 + d8; end
      4'd1: begin tk = 1; cc = 3; npc = pc + 20'd3 + d16; end
      4'd2: begin tk = 1; cc = 3; npc = {4'h0, op[15:0]}; end
      4'd3: begin tk = 1; cc = 3; npc = op; end
      4'd4: begin tk = 1; cc = 3; npc = {sg, a}; end
      4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10: begin
        case (k)
          4'd5:    tk = cy;
          4'd6:    tk = !cy;
          4'd7:    tk = z;
          4'd8:    tk = !z;
          4'd9:    tk = !(z || cy);
          default: tk = (z || cy);
        endcase
        len = (k >= 4'd9) ? 3 : 2;
        cc  = tk ? 3'd4 : 3'd2;
        npc = pc + 20'(len) + (tk ? d8 : 20'd0);
      end
      4'd11, 4'd12: begin
        tk  = tb;
        len = (k == 4'd11) ? 3 : 4;
        cc  = tk ? 3'd5 : 3'd3;
        npc = pc + 20'(len) + (tk ? d8 : 20'd0);
      end
      default: begin tk = 0; cc = 0; npc = pc; end
    endcase
  endfunction

  task automatic do_op(input string req, input logic [19:0] pc, input logic [3:0] k,
                       input logic [19:0] op, input logic [3:0] sg, input logic [15:0] a,
                       input logic z, input logic cy, input logic tb);
    logic [19:0] epc; logic etk; logic [2:0] ecc;
    @(negedge clk);
    in_valid = 1'b1; cur_pc = pc; kind = k; operand = op; seg = sg; ax = a;
    flag_z = z; flag_cy = cy; test_bit = tb;
    model(pc, k, op, sg, a, z, cy, tb, epc, etk, ecc);
    @(posedge clk); #1;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " pc"},    32'(next_pc),   32'(epc));
    chk({req, " taken"}, 32'(taken),     32'(etk));
    chk({req, " cycles"},32'(cycles),    32'(ecc));
    last_pc = epc; last_tk = etk; last_cc = ecc;
  endtask

  task automatic idle_hold();
    @(negedge clk);
    in_valid = 1'b0; cur_pc = $urandom(); kind = 4'($urandom());
    operand = 20'($urandom()); flag_z = ~flag_z; flag_cy = ~flag_cy;
    test_bit = ~test_bit; seg = ~seg; ax = ~ax;
    @(posedge clk); #1;
    chk("R2 idle valid", 32'(out_valid), 32'd0);
    chk("R2 hold pc",    32'(next_pc),   32'(last_pc));
    chk("R2 hold taken", 32'(taken),     32'(last_tk));
    chk("R2 hold cycles",32'(cycles),    32'(last_cc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b1d));
    rst_n = 1'b0; in_valid = 1'b0; cur_pc = '0; kind = '0; operand = '0;
    seg = '0; ax = '0; flag_z = 0; flag_cy = 0; test_bit = 0;
    repeat (3) @(posedge clk); #1;
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    chk("R1 reset pc",    32'(next_pc),   32'd0);
    chk("R1 reset taken", 32'(taken),     32'd0);
    chk("R1 reset cycles",32'(cycles),    32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    do_op("R3 rel8 fwd",        20'h01000, 4'd0, 20'h0007F, 4'h0, 16'h0, 0, 0, 0);
    do_op("R3 R13 rel8 neg@0",  20'h00000, 4'd0, 20'h00080, 4'h0, 16'h0, 0, 0, 0);
    do_op("R4 rel16 neg",       20'h12345, 4'd1, 20'h08000, 4'h0, 16'h0, 0, 0, 0);
    do_op("R4 R13 rel16 wrap",  20'hFFFF0, 4'd1, 20'h00100, 4'h0, 16'h0, 0, 0, 0);
    do_op("R5 abs16 high nib",  20'h54321, 4'd2, 20'hABCDE, 4'h0, 16'h0, 0, 0, 0);
    do_op("R5 abs20",           20'h00010, 4'd3, 20'hABCDE, 4'h0, 16'h0, 0, 0, 0);
    do_op("R6 regind",          20'h00010, 4'd4, 20'h00000, 4'hC, 16'h1234, 0, 0, 0);
    idle_hold();
    for (int m = 0; m < 4; m++) begin
      for (int k = 5; k <= 10; k++) begin
        do_op((k >= 9) ? "R8 R10 hi/nhi" : "R7 R10 cy/z", 20'h20000 + 20'(k*16),
              4'(k), 20'h000F0, 4'h0, 16'h0, m[1], m[0], 0);
      end
    end
    do_op("R9 bit l3 set",   20'h30000, 4'd11, 20'h00010, 4'h0, 16'h0, 0, 0, 1);
    do_op("R9 R10 bit l3 clr",20'h30000, 4'd11, 20'h00010, 4'h0, 16'h0, 0, 0, 0);
    do_op("R9 bit l4 set",   20'h30000, 4'd12, 20'h000FE, 4'h0, 16'h0, 0, 0, 1);
    do_op("R9 R10 bit l4 clr",20'hFFFFE, 4'd12, 20'h000FE, 4'h0, 16'h0, 0, 0, 0);
    do_op("R13 flag wrap",   20'hFFFFF, 4'd5, 20'h00001, 4'h0, 16'h0, 0, 1, 0);
    for (int k = 13; k <= 15; k++)
      do_op("R12 reserved", 20'h4A5A5, 4'(k), 20'hFFFFF, 4'hF, 16'hFFFF, 1, 1, 1);
    idle_hold();

    for (int i = 0; i < 400; i++) begin
      do_op("R11 random", 20'($urandom()), 4'($urandom_range(0, 15)), 20'($urandom()),
            4'($urandom()), 16'($urandom()), 1'($urandom()), 1'($urandom()),
            1'($urandom()));
      if ($urandom_range(0, 3) == 0) idle_hold();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule